// File: doc/BRIEF.md
# Residue-Domain Modular Multiplier (Sum of Residues)

This block multiplies two operands held in a residue number system and reduces the product modulo a large modulus `BIGM`. It never converts anything to binary. Each operand arrives as a vector of residues, one per channel, over `CH` pairwise co-prime channel moduli. The moduli share one word width `W` and are stored in ascending order. Every step of the work runs inside the short channels.

The product's residues are first scaled by the per-channel inverse constants. This gives one gamma per channel. Each gamma then multiplies the residue vector of its channel's cofactor reduced modulo `BIGM`. The resulting vectors are summed column by column, with no modular reduction. Alongside, a small adder tree estimates the integer alpha from the top `Q` bits of every gamma. Alpha picks a row from a correction table holding the residues of `(-alpha*D) mod BIGM`. That row is added, and each channel is then reduced by its own modulus. All constants are computed at elaboration from the parameters.

The result is congruent to A*B modulo `BIGM` but is only partly reduced. It stays small enough to be fed straight back as an operand. The pipeline accepts a new operation on every cycle.

Top module: `rns_sor_mulmod`

## Requirements
- R1: A synchronous active-high reset clears `done` and `z_res` to zero and discards every operation in flight, so no `done` follows a start issued before the reset.
- R2: When `start` is high at a rising edge, `done` is high for exactly one cycle, and that cycle begins on the fifth rising edge after the sampling edge.
- R3: Channel j of every residue vector occupies bits [j*W +: W], and channel 0 holds the smallest modulus. Every channel of `z_res` is below its own modulus.
- R4: For operands whose product is below half the dynamic range D, the integer that `z_res` represents is congruent to A*B modulo `BIGM`.
- R5: The represented result equals exactly sum_i gamma_i*(D_i mod BIGM) + ((-alpha*D) mod BIGM). Here gamma_i = (x_i * D_i^-1) mod m_i and alpha = floor(sum_i gamma_i/m_i). This means the estimated alpha always matches the true one.
- R6: The represented result is below (sum_i (m_i-1) + 1)*BIGM, so a result can serve as both operands of a later multiplication.
- R7: Starts on consecutive cycles are all accepted, and their results appear on consecutive cycles in issue order.
- R8: `z_res` changes only in the cycle in which `done` is high. Otherwise it holds, whatever the inputs do.
- R9: Operands are captured only at the edge that samples `start`. Changing `a_res` or `b_res` afterwards has no effect on that operation's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one multiplication with the present operands |
| a_res | input | CH*W | Residues of operand A, channel 0 in the low bits |
| b_res | input | CH*W | Residues of operand B, channel 0 in the low bits |
| z_res | output | CH*W | Residues of the partly reduced result |
| done | output | 1 | One-cycle pulse marking a new result on `z_res` |

## Verification
The bench uses the default build: four 8-bit channels with moduli 251, 253, 254 and 255, `BIGM` = 37, and six gamma bits feeding the alpha estimate. The dynamic range is just under 2^32. The bench can therefore rebuild every result from its residues with 64-bit arithmetic, using the Chinese remainder theorem, and compare it with the exact sum-of-residues value. Operands up to 44999 keep the product below D/2, drive alpha across its whole range 0 to 3, and leave room to feed a result back as both operands.

// File: rtl/rns_sor_pkg.sv
package rns_sor_pkg;

    localparam int unsigned DEF_CH   = 4;
    localparam int unsigned DEF_W    = 8;
    localparam int unsigned DEF_Q    = 6;
    localparam int unsigned DEF_BIGM = 37;
    // channel 0 in the low byte, ascending moduli
    localparam logic [DEF_CH*DEF_W-1:0] DEF_MODS = {8'd255, 8'd254, 8'd253, 8'd251};

    typedef logic [63:0] wide_t;

    // one register stage per algorithm step; the index is the stage's valid bit
    typedef enum logic [2:0] {
        ST_IN    = 3'd0,
        ST_PROD  = 3'd1,
        ST_GAMMA = 3'd2,
        ST_PROJ  = 3'd3,
        ST_SUM   = 3'd4,
        ST_FOLD  = 3'd5
    } stage_e;

    // multiplicative inverse by search; used only at elaboration on short moduli
    function automatic wide_t mod_inverse(input wide_t val, input wide_t modulus);
        wide_t found;
        found = 64'd0;
        for (wide_t t = 64'd1; t < modulus; t++) begin
            if (found == 64'd0 && ((val * t) % modulus) == 64'd1) begin
                found = t;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/rns_chan_reduce.sv
// Barrett reduction of an unsigned value by a constant channel modulus.
// Shift of IN_W+1 keeps the quotient estimate within one of the truth,
// so one conditional subtraction finishes the job.
module rns_chan_reduce #(
    parameter int unsigned IN_W = 16,
    parameter int unsigned W    = 8,
    parameter int unsigned MODV = 251
) (
    input  logic [IN_W-1:0] val,
    output logic [W-1:0]    res
);
    localparam int unsigned SH = IN_W + 1;
    localparam int unsigned KW = SH + 1;
    localparam int unsigned PW = IN_W + KW;
    localparam logic [KW-1:0]   KC     = KW'((64'd1 << SH) / 64'(MODV));
    localparam logic [IN_W-1:0] MOD_IN = IN_W'(MODV);

    logic [PW-1:0]   prod;
    logic [IN_W-1:0] quo;
    logic [IN_W-1:0] rem_raw;
    logic            unused_prod_bits;

    always_comb begin
        prod    = {{KW{1'b0}}, val} * {{IN_W{1'b0}}, KC};
        quo     = prod[SH +: IN_W];
        rem_raw = val - (quo * MOD_IN);
        res     = (rem_raw >= MOD_IN) ? W'(rem_raw - MOD_IN) : W'(rem_raw);
    end

    assign unused_prod_bits = ^{prod[SH-1:0], prod[PW-1]};

endmodule

// File: rtl/rns_alpha_est.sv
// Estimates alpha as floor(sum(gamma_i >> (W-Q)) / 2^Q + 1/2).
module rns_alpha_est #(
    parameter int unsigned CH   = 4,
    parameter int unsigned W    = 8,
    parameter int unsigned Q    = 6,
    parameter int unsigned AL_W = 3
) (
    input  logic [CH*W-1:0] gam,
    output logic [AL_W-1:0] alpha
);
    localparam int unsigned ACC_W = Q + $clog2(CH) + 1;
    localparam int unsigned DROP  = W - Q;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] shifted;

    always_comb begin
        acc = ACC_W'(1) << (Q - 1);
        for (int i = 0; i < CH; i++) begin
            acc = acc + ACC_W'(gam[i*W + DROP +: Q]);
        end
        shifted = acc >> Q;
        alpha   = AL_W'(shifted);
    end

    if (DROP > 0) begin : g_drop
        logic [CH*DROP-1:0] unused_low;
        for (genvar i = 0; i < CH; i++) begin : g_lo
            assign unused_low[i*DROP +: DROP] = gam[i*W +: DROP];
        end
    end

endmodule

// File: rtl/rns_col_sum.sv
// Plain (non-modular) sum of CH channel words, widened to SUM_W bits.
module rns_col_sum #(
    parameter int unsigned CH    = 4,
    parameter int unsigned W     = 8,
    parameter int unsigned SUM_W = 10
) (
    input  logic [CH*W-1:0]  terms,
    output logic [SUM_W-1:0] total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < CH; i++) begin
            total = total + SUM_W'(terms[i*W +: W]);
        end
    end
endmodule

// File: rtl/rns_sor_mulmod.sv
module rns_sor_mulmod
    import rns_sor_pkg::*;
#(
    parameter int unsigned     CH   = DEF_CH,
    parameter int unsigned     W    = DEF_W,
    parameter int unsigned     Q    = DEF_Q,
    parameter int unsigned     BIGM = DEF_BIGM,
    parameter logic [CH*W-1:0] MODS = DEF_MODS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CH*W-1:0] a_res,
    input  logic [CH*W-1:0] b_res,
    output logic [CH*W-1:0] z_res,
    output logic            done
);
    localparam int unsigned NSTG   = int'(ST_FOLD) + 1;
    localparam int unsigned AL_W   = $clog2(CH) + 1;
    localparam int unsigned SUM_W  = W + $clog2(CH);
    localparam int unsigned FOLD_W = SUM_W + 1;
    localparam int unsigned PROD_W = 2 * W;

    // ---------------- elaboration-time constants ----------------
    function automatic wide_t mod_of(input int unsigned idx);
        return wide_t'(MODS[idx*W +: W]);
    endfunction

    function automatic wide_t dyn_range();
        wide_t p;
        p = 64'd1;
        for (int unsigned i = 0; i < CH; i++) p = p * mod_of(i);
        return p;
    endfunction

    localparam wide_t DR = dyn_range();

    function automatic wide_t inv_const(input int unsigned i);
        return mod_inverse((DR / mod_of(i)) % mod_of(i), mod_of(i));
    endfunction

    function automatic wide_t proj_const(input int unsigned i, input int unsigned j);
        return ((DR / mod_of(i)) % wide_t'(BIGM)) % mod_of(j);
    endfunction

    function automatic wide_t corr_const(input int unsigned a, input int unsigned j);
        wide_t ad;
        ad = (wide_t'(a) * DR) % wide_t'(BIGM);
        return ((wide_t'(BIGM) - ad) % wide_t'(BIGM)) % mod_of(j);
    endfunction

    // ---------------- stage control ----------------
    logic [NSTG-1:0]    vld_q;
    logic [CH*W-1:0]    g_vec;
    logic [CH*CH*W-1:0] y_vec;
    logic [AL_W-1:0]    al_d, al_q;
    logic [CH*W-1:0]    z_vec;

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[NSTG-2:0], start};
    end

    // ---------------- steps 1 and 2: product, then gamma ----------------
    for (genvar j = 0; j < CH; j++) begin : g_chan
        localparam int unsigned    MJ   = int'(mod_of(j));
        localparam logic [W-1:0]   GINV = W'(inv_const(j));
        logic [W-1:0] a_q, b_q, x_d, x_q, g_d, g_q;

        always_ff @(posedge clk) begin
            if (start) begin
                a_q <= a_res[j*W +: W];
                b_q <= b_res[j*W +: W];
            end
            x_q <= x_d;
            g_q <= g_d;
        end

        rns_chan_reduce #(.IN_W(PROD_W), .W(W), .MODV(MJ)) u_red_x (
            .val ({{W{1'b0}}, a_q} * {{W{1'b0}}, b_q}),
            .res (x_d)
        );

        rns_chan_reduce #(.IN_W(PROD_W), .W(W), .MODV(MJ)) u_red_g (
            .val ({{W{1'b0}}, x_q} * {{W{1'b0}}, GINV}),
            .res (g_d)
        );

        assign g_vec[j*W +: W] = g_q;
    end

    // ---------------- step 4: projections gamma_i * (D_i mod M) mod m_j ----------------
    for (genvar i = 0; i < CH; i++) begin : g_src
        for (genvar j = 0; j < CH; j++) begin : g_dst
            localparam int unsigned  MJ = int'(mod_of(j));
            localparam logic [W-1:0] YC = W'(proj_const(i, j));
            logic [W-1:0] y_d, y_q;

            rns_chan_reduce #(.IN_W(PROD_W), .W(W), .MODV(MJ)) u_red_y (
                .val ({{W{1'b0}}, g_vec[i*W +: W]} * {{W{1'b0}}, YC}),
                .res (y_d)
            );

            always_ff @(posedge clk) y_q <= y_d;

            assign y_vec[(j*CH + i)*W +: W] = y_q;
        end
    end

    // ---------------- step 3: alpha estimate, concurrent with step 4 ----------------
    rns_alpha_est #(.CH(CH), .W(W), .Q(Q), .AL_W(AL_W)) u_alpha (
        .gam   (g_vec),
        .alpha (al_d)
    );

    always_ff @(posedge clk) al_q <= al_d;

    // alpha is exact for valid operands and so stays below the channel count
    AST_ALPHA_RANGE: assert property (@(posedge clk) disable iff (rst)
        vld_q[ST_PROJ] |-> (al_q < AL_W'(CH))); // R5

    // ---------------- steps 5 and 6: column sum, correction, final fold ----------------
    for (genvar j = 0; j < CH; j++) begin : g_out
        localparam int unsigned MJ = int'(mod_of(j));
        logic [CH*W-1:0]  ctab;
        logic [SUM_W-1:0] s_d, s_q;
        logic [W-1:0]     c_d, c_q, z_d, z_q;

        for (genvar k = 0; k < CH; k++) begin : g_tab
            assign ctab[k*W +: W] = W'(corr_const(k, j));
        end

        always_comb begin
            c_d = '0;
            for (int k = 0; k < CH; k++) begin
                if (al_q == AL_W'(k)) c_d = ctab[k*W +: W];
            end
        end

        rns_col_sum #(.CH(CH), .W(W), .SUM_W(SUM_W)) u_sum (
            .terms (y_vec[j*CH*W +: CH*W]),
            .total (s_d)
        );

        rns_chan_reduce #(.IN_W(FOLD_W), .W(W), .MODV(MJ)) u_red_z (
            .val (FOLD_W'(s_q) + FOLD_W'(c_q)),
            .res (z_d)
        );

        always_ff @(posedge clk) begin
            s_q <= s_d;
            c_q <= c_d;
            if (rst)                 z_q <= '0;
            else if (vld_q[ST_SUM])  z_q <= z_d;
        end

        assign z_vec[j*W +: W] = z_q;

        AST_RESIDUE_RANGE: assert property (@(posedge clk) disable iff (rst)
            z_q < W'(MJ)); // R3
    end

    assign z_res = z_vec;
    assign done  = vld_q[ST_FOLD];

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, NSTG)); // R2

    AST_Z_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(z_res)); // R8

endmodule

// File: tb/rns_sor_mulmod_bench.sv
module rns_sor_mulmod_bench;

    localparam int CH = 4;
    localparam int W  = 8;
    localparam longint unsigned BIG_M = 64'd37;
    localparam longint unsigned MD [CH] = '{64'd251, 64'd253, 64'd254, 64'd255};
    localparam longint unsigned DR = MD[0] * MD[1] * MD[2] * MD[3];
    localparam longint unsigned ZB = (MD[0] + MD[1] + MD[2] + MD[3] - 64'd3) * BIG_M;

    localparam int NV = 8;
    localparam longint unsigned VA [NV] = '{64'd1, 64'd2, 64'd12345, 64'd44999,
                                           64'd251, 64'd36, 64'd40000, 64'd30000};
    localparam longint unsigned VB [NV] = '{64'd1, 64'd3, 64'd6789, 64'd44999,
                                           64'd253, 64'd37, 64'd1, 64'd45000};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [CH*W-1:0] a_res = '0;
    logic [CH*W-1:0] b_res = '0;
    logic [CH*W-1:0] z_res;
    logic            done;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rns_sor_mulmod u_rns_sor_mulmod (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .a_res (a_res),
        .b_res (b_res),
        .z_res (z_res),
        .done  (done)
    );

    // ---------------- reference arithmetic ----------------
    function automatic longint unsigned inv_of(input longint unsigned v, input longint unsigned m);
        longint unsigned r;
        r = 0;
        for (longint unsigned t = 1; t < m; t++) if (r == 0 && (v * t) % m == 1) r = t;
        return r;
    endfunction

    function automatic logic [CH*W-1:0] to_res(input longint unsigned x);
        logic [CH*W-1:0] v;
        for (int j = 0; j < CH; j++) v[j*W +: W] = W'(x % MD[j]);
        return v;
    endfunction

    function automatic longint unsigned crt(input logic [CH*W-1:0] v);
        longint unsigned s, dj, zj;
        s = 0;
        for (int j = 0; j < CH; j++) begin
            dj = DR / MD[j];
            zj = longint'(v[j*W +: W]);
            s  = (s + ((zj * dj) % DR) * inv_of(dj % MD[j], MD[j])) % DR;
        end
        return s;
    endfunction

    function automatic longint unsigned expect_z(input longint unsigned x);
        longint unsigned g, di, acc, z, al;
        acc = 0;
        z   = 0;
        for (int i = 0; i < CH; i++) begin
            di  = DR / MD[i];
            g   = ((x % MD[i]) * inv_of(di % MD[i], MD[i])) % MD[i];
            acc = acc + g * di;
            z   = z + g * (di % BIG_M);
        end
        al = acc / DR;
        return z + (BIG_M - (al * DR) % BIG_M) % BIG_M;
    endfunction

    task automatic chk(input bit ok, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic check_result(input longint unsigned a, input longint unsigned b,
                                output longint unsigned zv);
        longint unsigned ex, x;
        x  = a * b;
        ex = expect_z(x);
        zv = crt(z_res);
        chk(z_res == to_res(ex), "R5 exact sum-of-residues value", zv, ex);
        chk(zv % BIG_M == x % BIG_M, "R4 congruent to A*B mod M", zv % BIG_M, x % BIG_M);
        chk(zv < ZB, "R6 result bound", zv, ZB);
        for (int j = 0; j < CH; j++)
            chk(longint'(z_res[j*W +: W]) < MD[j], "R3 residue below modulus",
                longint'(z_res[j*W +: W]), MD[j]);
    endtask

    // issue at a negedge, scramble operands right after capture, check timing
    task automatic do_op(input longint unsigned a, input longint unsigned b,
                         output longint unsigned zv);
        logic [CH*W-1:0] held;
        a_res = to_res(a);
        b_res = to_res(b);
        start = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0;
                a_res = '1;
                b_res = 32'h5A5A_5A5A;
            end
            chk(done == 1'b0, "R2 done not yet due", longint'(done), 0);
        end
        @(negedge clk);
        chk(done == 1'b1, "R2 done on fifth edge", longint'(done), 1);
        check_result(a, b, zv);
        chk(z_res == to_res(expect_z(a * b)), "R9 operands taken at start edge",
            crt(z_res), expect_z(a * b));
        held = z_res;
        @(negedge clk);
        chk(done == 1'b0, "R2 done lasts one cycle", longint'(done), 0);
        chk(z_res == held, "R8 result holds", longint'(z_res), longint'(held));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        longint unsigned zv, zc;
        logic [CH*W-1:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(z_res == '0, "R1 z cleared in reset", longint'(z_res), 0);
        chk(done == 1'b0, "R1 done low in reset", longint'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(z_res == '0, "R1 z zero after reset", longint'(z_res), 0);

        // table of operand pairs
        for (int v = 0; v < NV; v++) do_op(VA[v], VB[v], zv);

        // zero operand
        do_op(64'd0, 64'd44999, zv);
        chk(zv == expect_z(0), "R5 zero operand", zv, expect_z(0));

        // R6: result fed back as both operands
        do_op(64'd44999, 64'd44999, zc);
        do_op(zc, zc, zv);
        chk(zv % BIG_M == (zc * zc) % BIG_M, "R6 chained result congruent",
            zv % BIG_M, (zc * zc) % BIG_M);

        // R8: inputs wiggle with no start, result must not move
        held = z_res;
        for (int k = 0; k < 8; k++) begin
            a_res = to_res(64'd1000 + longint'(k));
            b_res = to_res(64'd77 * longint'(k));
            @(negedge clk);
            chk(z_res == held && done == 1'b0, "R8 no start, no change",
                longint'(z_res), longint'(held));
        end

        // R7: three back-to-back starts
        a_res = to_res(64'd111);   b_res = to_res(64'd222);   start = 1'b1;
        @(negedge clk);
        a_res = to_res(64'd4321);  b_res = to_res(64'd9876);
        @(negedge clk);
        a_res = to_res(64'd33333); b_res = to_res(64'd44444);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R7 first result", longint'(done), 1);
        check_result(64'd111, 64'd222, zv);
        @(negedge clk);
        chk(done == 1'b1, "R7 second result", longint'(done), 1);
        check_result(64'd4321, 64'd9876, zv);
        @(negedge clk);
        chk(done == 1'b1, "R7 third result", longint'(done), 1);
        check_result(64'd33333, 64'd44444, zv);
        @(negedge clk);
        chk(done == 1'b0, "R7 pipeline drained", longint'(done), 0);

        // R1: reset in the middle of an operation discards it
        a_res = to_res(64'd500); b_res = to_res(64'd600); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(done == 1'b0 && z_res == '0, "R1 in-flight work discarded",
                longint'(z_res), 0);
        end

        finish_run();
    end

endmodule